// File: doc/BRIEF.md
# Three-Deep CAN Receive Message Queue

This block holds accepted CAN frames between the acceptance filter and the CPU. Each entry carries a 29-bit identifier, a 4-bit data length code and eight data bytes. Up to three frames are held. The filter stage offers a frame with a one-cycle `in_valid` strobe. The CPU reads the oldest frame on the output port and releases it with `out_ready`. A chip with two receive queues instantiates this block twice.

The input side has no ready signal, because a CAN receiver cannot stall the bus. When the queue is full and nothing is released in the same cycle, the arriving frame is an overrun. The `lock_mode` input picks what happens next. With lock mode off, the arriving frame replaces the newest stored frame. With lock mode on, the arriving frame is dropped.

The output side is valid/ready. `out_valid` is high while at least one frame is held. A handshake (`out_valid && out_ready`) drops the oldest frame. `out_ready` has no effect while `out_valid` is low. Status consists of a pending count, a full flag and a sticky overrun flag. Each of the three has its own interrupt enable.

Top module: `canrx_fifo`

## Requirements
- R1: After reset, `pend_cnt` is 0 and `out_valid`, `full_flag`, `ovr_flag` and all three interrupt outputs are 0.
- R2: `pend_cnt` equals the number of frames held, and `out_valid` is 1 exactly when that number is nonzero. The output fields show the oldest held frame, and frames leave in arrival order. A frame written at a clock edge is counted from that edge on.
- R3: A handshake removes the oldest frame and lowers `pend_cnt` by one at the same edge. `out_ready` while the queue is empty changes nothing.
- R4: When an input frame and a handshake arrive in the same cycle with three frames held, the frame is stored, `pend_cnt` stays 3 and no overrun is flagged.
- R5: `full_flag` rises at the edge where the count goes from 2 to 3. A one-cycle pulse on `clr_full` clears it. It also clears by itself at the edge where a handshake takes the count below 3. A rising event in the same cycle as a clear wins.
- R6: An input frame that arrives while three frames are held and no handshake happens sets `ovr_flag`. The count stays 3. The flag stays set until a `clr_ovr` pulse, and a new overrun in the same cycle as the clear wins.
- R7: With `lock_mode` = 0, an overrun frame replaces the newest stored frame. The two older frames are unchanged.
- R8: With `lock_mode` = 1, an overrun frame is discarded and all stored frames are unchanged.
- R9: `irq_pend` = (`pend_cnt` != 0) AND `ie_pend`, `irq_full` = `full_flag` AND `ie_full`, and `irq_ovr` = `ovr_flag` AND `ie_ovr`.
- R10: `clr_full` and `clr_ovr` never change `pend_cnt` or the stored frames. The count changes only through writes and handshakes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame strobe from the filter stage |
| in_id | input | 29 | Incoming identifier |
| in_dlc | input | 4 | Incoming data length code |
| in_data | input | 64 | Incoming payload bytes |
| lock_mode | input | 1 | 1: drop the incoming frame on overrun; 0: overwrite the newest frame |
| out_valid | output | 1 | A frame is available |
| out_ready | input | 1 | Release the oldest frame |
| out_id | output | 29 | Oldest frame identifier |
| out_dlc | output | 4 | Oldest frame length code |
| out_data | output | 64 | Oldest frame payload |
| pend_cnt | output | 2 | Number of frames held |
| full_flag | output | 1 | Queue reached three frames |
| ovr_flag | output | 1 | Sticky overrun indication |
| clr_full | input | 1 | Write-one-to-clear pulse for `full_flag` |
| clr_ovr | input | 1 | Write-one-to-clear pulse for `ovr_flag` |
| ie_pend | input | 1 | Enables the pending interrupt |
| ie_full | input | 1 | Enables the full interrupt |
| ie_ovr | input | 1 | Enables the overrun interrupt |
| irq_pend | output | 1 | Pending interrupt |
| irq_full | output | 1 | Full interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
The assertions assume that `in_valid`, `out_ready` and the clear pulses are sampled only at clock edges, and that the `lock_mode` value seen in an overrun cycle is the one that counts. They make no assumption that `out_ready` stays off while the queue is empty, and they allow writes at any rate.

The stimulus changes all inputs one nanosecond after a rising edge, so each value is stable for a whole cycle. A directed phase walks through empty release, fill, swap at full, overrun in both lock settings and flag clears. A pseudo-random sweep then drives every control input freely, including `out_ready` on an empty queue, back-to-back overruns and `lock_mode` changing between cycles.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } frame_t;

  localparam int FRAME_W = $bits(frame_t);
endpackage

// File: rtl/canrx_store.sv
module canrx_store #(
  parameter int DEPTH = 3,
  parameter int MSG_W = 97,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [MSG_W-1:0] in_msg,
  input  logic             lock_mode,
  input  logic             release_req,
  output logic [MSG_W-1:0] head_msg,
  output logic [CNT_W-1:0] cnt,
  output logic             fill_evt,
  output logic             drain_evt,
  output logic             ovr_evt
);
  logic [DEPTH-1:0][MSG_W-1:0] mem_q;
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q, newest_idx;
  logic [CNT_W-1:0] cnt_q;
  logic pop, push, room, ovw;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    room       = (cnt_q != CNT_W'(DEPTH));
    pop        = release_req && (cnt_q != '0);
    push       = in_valid && (room || pop);
    ovr_evt    = in_valid && !room && !pop;
    ovw        = ovr_evt && !lock_mode;
    newest_idx = (wr_ptr_q == '0) ? PTR_W'(DEPTH - 1) : wr_ptr_q - PTR_W'(1);
    fill_evt   = push && !pop && (cnt_q == CNT_W'(DEPTH - 1));
    drain_evt  = pop && !push && (cnt_q == CNT_W'(DEPTH));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic we;
    assign we = (push && (wr_ptr_q == PTR_W'(i))) || (ovw && (newest_idx == PTR_W'(i)));
    always_ff @(posedge clk) begin
      if (!rst_n)  mem_q[i] <= '0;
      else if (we) mem_q[i] <= in_msg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_msg = mem_q[rd_ptr_q];
  assign cnt      = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R2
  AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (release_req && cnt_q == '0 && !in_valid) |=> (cnt_q == '0)); // R3
  AST_SWAP_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && release_req && cnt_q == CNT_W'(DEPTH)) |=> (cnt_q == CNT_W'(DEPTH))); // R4
  AST_OVR_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (cnt_q == CNT_W'(DEPTH))); // R6
  AST_LOCK_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && lock_mode) |=> $stable(mem_q)); // R8
endmodule

// File: rtl/canrx_flags.sv
module canrx_flags #(
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             fill_evt,
  input  logic             drain_evt,
  input  logic             ovr_evt,
  input  logic             clr_full,
  input  logic             clr_ovr,
  output logic             full_q,
  output logic             ovr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (fill_evt)                   full_q <= 1'b1;
      else if (drain_evt || clr_full) full_q <= 1'b0;
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;
    end
  end

  AST_FULL_NEEDS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (cnt == CNT_W'(DEPTH))); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_ovr) |=> ovr_q); // R6
endmodule

// File: rtl/canrx_irq.sv
module canrx_irq #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             full,
  input  logic             ovr,
  input  logic             ie_pend,
  input  logic             ie_full,
  input  logic             ie_ovr,
  output logic             irq_pend,
  output logic             irq_full,
  output logic             irq_ovr
);
  assign irq_pend = (cnt != '0) && ie_pend;
  assign irq_full = full && ie_full;
  assign irq_ovr  = ovr && ie_ovr;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_pend && !ie_full && !ie_ovr) |-> !(irq_pend || irq_full || irq_ovr)); // R9
endmodule

// File: rtl/canrx_fifo.sv
module canrx_fifo
  import canrx_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DLC_W-1:0]  in_dlc,
  input  logic [DATA_W-1:0] in_data,
  input  logic              lock_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [DLC_W-1:0]  out_dlc,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  pend_cnt,
  output logic              full_flag,
  output logic              ovr_flag,
  input  logic              clr_full,
  input  logic              clr_ovr,
  input  logic              ie_pend,
  input  logic              ie_full,
  input  logic              ie_ovr,
  output logic              irq_pend,
  output logic              irq_full,
  output logic              irq_ovr
);
  frame_t in_frm, head_frm;
  logic [FRAME_W-1:0] head_bits;
  logic fill_evt, drain_evt, ovr_evt;

  assign in_frm = '{id: in_id, dlc: in_dlc, data: in_data};

  canrx_store #(.DEPTH(DEPTH), .MSG_W(FRAME_W)) u_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_frm),
    .lock_mode(lock_mode), .release_req(out_ready), .head_msg(head_bits),
    .cnt(pend_cnt), .fill_evt(fill_evt), .drain_evt(drain_evt), .ovr_evt(ovr_evt)
  );

  canrx_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .cnt(pend_cnt), .fill_evt(fill_evt),
    .drain_evt(drain_evt), .ovr_evt(ovr_evt), .clr_full(clr_full),
    .clr_ovr(clr_ovr), .full_q(full_flag), .ovr_q(ovr_flag)
  );

  canrx_irq #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .cnt(pend_cnt), .full(full_flag), .ovr(ovr_flag),
    .ie_pend(ie_pend), .ie_full(ie_full), .ie_ovr(ie_ovr),
    .irq_pend(irq_pend), .irq_full(irq_full), .irq_ovr(irq_ovr)
  );

  assign head_frm  = frame_t'(head_bits);
  assign out_valid = (pend_cnt != '0);
  assign out_id    = head_frm.id;
  assign out_dlc   = head_frm.dlc;
  assign out_data  = head_frm.data;

  AST_CLEAR_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !out_ready) |=> $stable(pend_cnt)); // R10
endmodule

// File: tb/tb_canrx_fifo.sv
`timescale 1ns/1ps
module tb_canrx_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, lock_mode = 0, out_ready = 0, clr_full = 0, clr_ovr = 0;
  logic ie_pend = 0, ie_full = 0, ie_ovr = 0;
  logic [28:0] in_id = '0;
  logic [3:0]  in_dlc = '0;
  logic [63:0] in_data = '0;
  logic out_valid, full_flag, ovr_flag, irq_pend, irq_full, irq_ovr;
  logic [28:0] out_id;
  logic [3:0]  out_dlc;
  logic [63:0] out_data;
  logic [1:0]  pend_cnt;

  int tests = 0, fails = 0;
  int mq[3];
  int mc = 0;
  bit mfull = 0, movr = 0;
  int nser = 1;
  string phase = "reset";
  logic [31:0] lfsr = 32'hACE1_2357;

  always #4 clk = ~clk;

  canrx_fifo dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id), .in_dlc(in_dlc),
    .in_data(in_data), .lock_mode(lock_mode), .out_valid(out_valid), .out_ready(out_ready),
    .out_id(out_id), .out_dlc(out_dlc), .out_data(out_data), .pend_cnt(pend_cnt),
    .full_flag(full_flag), .ovr_flag(ovr_flag), .clr_full(clr_full), .clr_ovr(clr_ovr),
    .ie_pend(ie_pend), .ie_full(ie_full), .ie_ovr(ie_ovr),
    .irq_pend(irq_pend), .irq_full(irq_full), .irq_ovr(irq_ovr)
  );

  function automatic logic [28:0] id_of(int s);   return 29'(s * 7 + 3); endfunction
  function automatic logic [3:0]  dlc_of(int s);  return 4'(s);          endfunction
  function automatic logic [63:0] data_of(int s); return {32'(s), ~32'(s)}; endfunction

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 count", pend_cnt, mc);
    chk("R2 valid", out_valid, mc != 0);
    if (mc != 0) begin
      chk("R2 id", out_id, id_of(mq[0]));
      chk("R2 dlc", out_dlc, dlc_of(mq[0]));
      chk("R2 data", out_data, data_of(mq[0]));
    end
    chk("R5 full", full_flag, mfull);
    chk("R6 ovr", ovr_flag, movr);
    chk("R9 irq_pend", irq_pend, (mc != 0) && ie_pend);
    chk("R9 irq_full", irq_full, mfull && ie_full);
    chk("R9 irq_ovr", irq_ovr, movr && ie_ovr);
  endtask

  task automatic step(bit iv, bit ord, bit cf, bit co, bit lk);
    bit pop, room, push, oe, fill, drain;
    int old;
    in_valid = iv; out_ready = ord; clr_full = cf; clr_ovr = co; lock_mode = lk;
    in_id = id_of(nser); in_dlc = dlc_of(nser); in_data = data_of(nser);
    @(posedge clk);
    pop = ord && mc > 0; room = mc < 3; push = iv && (room || pop);
    oe = iv && !room && !pop; old = mc;
    if (pop) begin mq[0] = mq[1]; mq[1] = mq[2]; mc--; end
    if (push) begin mq[mc] = nser; mc++; end
    if (oe && !lk) mq[2] = nser;
    fill = push && !pop && old == 2;
    drain = pop && !push && old == 3;
    mfull = fill ? 1'b1 : ((drain || cf) ? 1'b0 : mfull);
    movr = oe ? 1'b1 : (co ? 1'b0 : movr);
    if (iv) nser++;
    #1;
    compare_all();
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    ie_pend = 1; ie_full = 1; ie_ovr = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    phase = "R1";
    chk("R1 count", pend_cnt, 0);
    chk("R1 valid", out_valid, 0);
    chk("R1 full", full_flag, 0);
    chk("R1 ovr", ovr_flag, 0);
    chk("R1 irqs", {irq_pend, irq_full, irq_ovr}, 0);

    phase = "R3 empty release";
    step(0, 1, 0, 0, 0);
    chk("R3 count after empty release", pend_cnt, 0);

    phase = "R5 fill";
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    chk("R5 full at three", full_flag, 1);

    phase = "R4 swap at full";
    step(1, 1, 0, 0, 0);
    chk("R4 count stays", pend_cnt, 3);
    chk("R4 no overrun", ovr_flag, 0);

    phase = "R7 overwrite newest";
    step(1, 0, 0, 0, 0);
    chk("R7 oldest kept", out_id, id_of(2));
    step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
    chk("R7 newest replaced", out_id, id_of(5));
    chk("R5 auto clear", full_flag, 0);

    phase = "R10 clears";
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0);
    chk("R10 count unchanged by clears", pend_cnt, 3);
    chk("R10 head unchanged by clears", out_id, id_of(5));

    phase = "R8 lock discard";
    step(1, 0, 0, 0, 1);
    chk("R8 flag set", ovr_flag, 1);
    step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
    chk("R8 newest kept", out_id, id_of(8));
    step(0, 1, 0, 0, 0);
    chk("R8 drained", pend_cnt, 0);

    phase = "R6 set wins over clear";
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 1, 0);
    step(1, 0, 0, 1, 1);
    chk("R6 overrun beats clear", ovr_flag, 1);

    phase = "R9 sweep";
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ie_pend = lfsr[8]; ie_full = lfsr[9]; ie_ovr = lfsr[10];
      step(lfsr[3] | lfsr[12], lfsr[4] & lfsr[13], lfsr[5] & lfsr[14] & lfsr[15],
           lfsr[6] & lfsr[16] & lfsr[17], lfsr[7]);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule